// File: doc/BRIEF.md
# NVM Pointer-Walking Checksum Engine

This block computes a 16-bit additive checksum over a non-volatile memory image held in an attached word-addressable memory. A pulse on the start input begins a pass. The engine first adds up every word of a fixed header region. It then visits a set of pointer slots inside that header, in ascending slot order. A pointer that passes its range checks leads to a length word. If the length is also valid, the payload words of that section are added to the running sum. The result is the value that, added to the sum, yields a fixed constant. In effect, this is the word that belongs in the checksum slot at address 0x3F.

In verify mode, the engine also fetches the stored checksum word once the result is known. It raises a mismatch flag when the stored word differs from the computed value. The memory is reached through a plain request/response read port with one request in flight at a time. The caller supplies the memory size in words, and every pointer and length is checked against it. Arbitration for the memory and any write-back of the result belong to the surrounding logic.

Top module: `nvm_csum_walker`

## Requirements
- R1: After reset, and whenever no pass is running, busy_o, done_o, mismatch_o and mem_rd_o are low. A read request is only issued while busy_o is high.
- R2: Words at addresses 0x00 to 0x3E are always added. csum_o equals SUM_CONST (default 16'hBABA) minus the 16-bit wrapped sum. An all-zero image therefore gives 16'hBABA.
- R3: Pointer slots 0x03 and 0x06 to 0x0E are read, in ascending order. Slots 0x04, 0x05 and 0x0F and above are never read as pointers.
- R4: A pointer equal to 16'hFFFF, equal to 0, or not below words_i is skipped without reading its length word.
- R5: A length equal to 16'hFFFF or 0 skips its section. So does a length for which pointer + length is not below words_i. A pointer + length of exactly words_i - 1 is accepted.
- R6: For a valid section, the words at pointer+1 through pointer+length inclusive are each added once.
- R7: With verify_i high at start, one extra read of address 0x3F follows the walk. mismatch_o is high at done exactly when that word differs from csum_o. With verify_i low, no such read occurs and mismatch_o stays low.
- R8: A response with mem_err_i high is never added. An error in the header ends the header and begins the walk. An error on a pointer or length read ends the walk. An error on a section word ends only that section. An error on the verify read sets mismatch_o.
- R9: At most one read is outstanding. mem_rd_o is not raised again until the previous request's mem_rvalid_i has arrived.
- R10: done_o is a single-cycle pulse that ends the pass, and busy_o is low in the cycle after it. csum_o and mismatch_o hold their values until the next pass ends (mismatch_o clears when a pass starts).
- R11: A start pulse while busy_o is high has no effect on the running pass, its read count or its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a pass (sampled while idle) |
| verify_i | input | 1 | Compare result with stored word at 0x3F (sampled with start) |
| words_i | input | 17 | Memory size in words, used for range checks |
| mem_addr_o | output | 16 | Read address |
| mem_rd_o | output | 1 | Read request strobe, one cycle |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_err_i | input | 1 | Response carries an error (qualified by mem_rvalid_i) |
| mem_rdata_i | input | 16 | Read response data |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle pass completion pulse |
| csum_o | output | 16 | Computed checksum value |
| mismatch_o | output | 1 | Stored checksum differs or could not be read |

## Verification
The checksum is exercised with these images:
- A patterned header with empty pointers, which isolates the header sum.
- An all-zero image, which pins the constant.
- A table in which every slot, including the skipped ones and the slot past the end, points at a valid section. Here the read count and the sum reveal which slots were followed.
- A table of pointers and lengths placed on each side of every range limit, run at two memory sizes.

Verify mode is tried with a matching stored word and a flipped one. Injected read errors in each phase distinguish "abandon the section" from "abandon the walk". A second start pulse mid-pass shows whether the running pass is disturbed.

// File: rtl/nvm_csum_pkg.sv
package nvm_csum_pkg;

    // Sequencer state: a request is issued, then its response awaited.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FIN   = 2'd3
    } walk_st_e;

    // What the outstanding read is for.
    typedef enum logic [2:0] {
        PH_HDR = 3'd0,
        PH_PTR = 3'd1,
        PH_LEN = 3'd2,
        PH_SEC = 3'd3,
        PH_CHK = 3'd4
    } walk_ph_e;

endpackage

// File: rtl/nvm_ptr_sel.sv
// Picks the next pointer slot to follow: lowest eligible slot above cur,
// or the lowest eligible slot overall when from_start is set.
module nvm_ptr_sel #(
    parameter int          SLOT_FIRST = 3,
    parameter int          SLOT_END   = 15,
    parameter logic [31:0] SKIP_MASK  = 32'h0000_0030,
    parameter int          SW         = $clog2(SLOT_END + 1)
) (
    input  logic          from_start,
    input  logic [SW-1:0] cur,
    output logic [SW-1:0] nxt,
    output logic          nxt_ok
);

    logic [SLOT_END-1:0] elig;

    genvar k;
    generate
        for (k = 0; k < SLOT_END; k++) begin : g_slot
            localparam bit FOLLOW = (k >= SLOT_FIRST) && !SKIP_MASK[k];
            if (FOLLOW) begin : g_on
                assign elig[k] = from_start || (SW'(k) > cur);
            end else begin : g_off
                assign elig[k] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        nxt    = '0;
        nxt_ok = 1'b0;
        for (int i = SLOT_END - 1; i >= 0; i--) begin
            if (elig[i]) begin
                nxt    = SW'(i);
                nxt_ok = 1'b1;
            end
        end
    end

endmodule

// File: rtl/nvm_range_chk.sv
// Validity tests for a section pointer and its length word.
module nvm_range_chk #(
    parameter int W = 16
) (
    input  logic [W-1:0] ptr,
    input  logic [W-1:0] len,
    input  logic [W:0]   words,
    output logic         ptr_ok,
    output logic         len_ok
);

    logic [W:0] span_end;

    assign span_end = {1'b0, ptr} + {1'b0, len};

    assign ptr_ok = (ptr != '1) && (ptr != '0) && ({1'b0, ptr} < words);
    assign len_ok = (len != '1) && (len != '0) && (span_end < words);

endmodule

// File: rtl/nvm_csum_walker.sv
module nvm_csum_walker
    import nvm_csum_pkg::*;
#(
    parameter int          W          = 16,
    parameter int          HDR_WORDS  = 63,
    parameter int          CSUM_ADDR  = 63,
    parameter int          SLOT_FIRST = 3,
    parameter int          SLOT_END   = 15,
    parameter logic [31:0] SKIP_MASK  = 32'h0000_0030,
    parameter logic [15:0] SUM_CONST  = 16'hBABA
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         verify_i,
    input  logic [W:0]   words_i,
    output logic [W-1:0] mem_addr_o,
    output logic         mem_rd_o,
    input  logic         mem_rvalid_i,
    input  logic         mem_err_i,
    input  logic [W-1:0] mem_rdata_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] csum_o,
    output logic         mismatch_o
);

    localparam int          SW       = $clog2(SLOT_END + 1);
    localparam logic [W-1:0] HDR_LAST = W'(HDR_WORDS - 1);
    localparam logic [W-1:0] CHK_ADR  = W'(CSUM_ADDR);
    localparam logic [W-1:0] K_SUM    = W'(SUM_CONST);

    typedef struct packed {
        walk_st_e     st;
        walk_ph_e     ph;
        logic         vfy;
        logic [W-1:0] addr;
        logic [W-1:0] sum;
        logic [W-1:0] ptr;
        logic [W-1:0] left;
        logic [W-1:0] res;
        logic [SW-1:0] slot;
        logic         mism;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic          sel_from_start;
    logic [SW-1:0] sel_nxt;
    logic          sel_ok;
    logic [W-1:0]  chk_ptr;
    logic          ptr_ok, len_ok;

    assign sel_from_start = (r_q.ph == PH_HDR);
    assign chk_ptr        = (r_q.ph == PH_PTR) ? mem_rdata_i : r_q.ptr;

    nvm_ptr_sel #(
        .SLOT_FIRST (SLOT_FIRST),
        .SLOT_END   (SLOT_END),
        .SKIP_MASK  (SKIP_MASK),
        .SW         (SW)
    ) u_sel (
        .from_start (sel_from_start),
        .cur        (r_q.slot),
        .nxt        (sel_nxt),
        .nxt_ok     (sel_ok)
    );

    nvm_range_chk #(
        .W (W)
    ) u_rng (
        .ptr    (chk_ptr),
        .len    (mem_rdata_i),
        .words  (words_i),
        .ptr_ok (ptr_ok),
        .len_ok (len_ok)
    );

    always_comb begin
        logic adv;
        logic fin;
        r_d = r_q;
        adv = 1'b0;
        fin = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_ISSUE;
                    r_d.ph   = PH_HDR;
                    r_d.vfy  = verify_i;
                    r_d.addr = '0;
                    r_d.sum  = '0;
                    r_d.slot = '0;
                    r_d.mism = 1'b0;
                end
            end
            ST_ISSUE: begin
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    unique case (r_q.ph)
                        PH_HDR: begin
                            if (mem_err_i) begin
                                adv = 1'b1;
                            end else begin
                                r_d.sum = r_q.sum + mem_rdata_i;
                                if (r_q.addr == HDR_LAST) begin
                                    adv = 1'b1;
                                end else begin
                                    r_d.addr = r_q.addr + 1'b1;
                                    r_d.st   = ST_ISSUE;
                                end
                            end
                        end
                        PH_PTR: begin
                            if (mem_err_i) begin
                                fin = 1'b1;
                            end else if (!ptr_ok) begin
                                adv = 1'b1;
                            end else begin
                                r_d.ptr  = mem_rdata_i;
                                r_d.addr = mem_rdata_i;
                                r_d.ph   = PH_LEN;
                                r_d.st   = ST_ISSUE;
                            end
                        end
                        PH_LEN: begin
                            if (mem_err_i) begin
                                fin = 1'b1;
                            end else if (!len_ok) begin
                                adv = 1'b1;
                            end else begin
                                r_d.left = mem_rdata_i;
                                r_d.addr = r_q.ptr + 1'b1;
                                r_d.ph   = PH_SEC;
                                r_d.st   = ST_ISSUE;
                            end
                        end
                        PH_SEC: begin
                            if (mem_err_i) begin
                                adv = 1'b1;
                            end else begin
                                r_d.sum = r_q.sum + mem_rdata_i;
                                if (r_q.left == W'(1)) begin
                                    adv = 1'b1;
                                end else begin
                                    r_d.left = r_q.left - 1'b1;
                                    r_d.addr = r_q.addr + 1'b1;
                                    r_d.st   = ST_ISSUE;
                                end
                            end
                        end
                        PH_CHK: begin
                            r_d.mism = mem_err_i || (mem_rdata_i != r_q.res);
                            r_d.st   = ST_FIN;
                        end
                        default: begin
                            r_d.st = ST_FIN;
                        end
                    endcase
                end
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        // Move on to the next pointer slot, or end the walk.
        if (adv) begin
            if (sel_ok) begin
                r_d.slot = sel_nxt;
                r_d.addr = W'(sel_nxt);
                r_d.ph   = PH_PTR;
                r_d.st   = ST_ISSUE;
            end else begin
                fin = 1'b1;
            end
        end

        if (fin) begin
            r_d.res = K_SUM - r_d.sum;
            if (r_q.vfy) begin
                r_d.ph   = PH_CHK;
                r_d.addr = CHK_ADR;
                r_d.st   = ST_ISSUE;
            end else begin
                r_d.st = ST_FIN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd_o   = (r_q.st == ST_ISSUE);
    assign mem_addr_o = r_q.addr;
    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = (r_q.st == ST_FIN);
    assign csum_o     = r_q.res;
    assign mismatch_o = r_q.mism;

endmodule

// File: rtl/nvm_csum_walker_chk.sv
module nvm_csum_walker_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         mem_rd_o,
    input logic         mem_rvalid_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] csum_o,
    input logic         mismatch_o
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (mem_rd_o) begin
            pend_q <= 1'b1;
        end else if (mem_rvalid_i) begin
            pend_q <= 1'b0;
        end
    end

    // R9
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> !pend_q);

    // R1
    rd_in_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> busy_o);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(csum_o));

    // R7
    mism_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mismatch_o) |-> done_o);

    // R11
    restart_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !done_o) |=> busy_o);

endmodule

bind nvm_csum_walker nvm_csum_walker_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mem_rd_o     (mem_rd_o),
    .mem_rvalid_i (mem_rvalid_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .csum_o       (csum_o),
    .mismatch_o   (mismatch_o)
);

// File: tb/sim_nvm_csum_walker.sv
`timescale 1ns/1ps
module sim_nvm_csum_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        verify = 1'b0;
    logic [16:0] words = 17'd1024;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_rvalid = 1'b0;
    logic        mem_err = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        busy, done, mismatch;
    logic [15:0] csum;

    always #4 clk = ~clk;

    nvm_csum_walker u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .verify_i(verify),
        .words_i(words), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
        .mem_rvalid_i(mem_rvalid), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .done_o(done), .csum_o(csum), .mismatch_o(mismatch)
    );

    // Memory model: one-cycle response, optional error at one address.
    logic [15:0] mem [0:1023];
    logic        err_en = 1'b0;
    int          err_addr = 0;
    int          rd_total = 0;
    int          overlap = 0;
    logic        pend = 1'b0;

    always @(posedge clk) begin
        mem_rvalid <= mem_rd;
        mem_rdata  <= mem[mem_addr[9:0]];
        mem_err    <= mem_rd && err_en && (int'(mem_addr) == err_addr);
        if (mem_rd) rd_total <= rd_total + 1;
        if (mem_rd && pend) overlap <= overlap + 1;
        pend <= mem_rd ? 1'b1 : (mem_rvalid ? 1'b0 : pend);
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic bit bad(input int a);
        return err_en && (a == err_addr);
    endfunction

    // Reference computed from the requirements.
    function automatic void model(input logic vfy, input int wsz,
                                  output logic [15:0] res, output logic mm, output int nrd);
        logic [15:0] s = '0;
        int p, l;
        bit stop = 0;
        nrd = 0;
        for (int a = 0; a < 63; a++) begin
            nrd++;
            if (bad(a)) break;
            s += mem[a];
        end
        for (int i = 3; i < 15 && !stop; i++) begin
            if (i == 4 || i == 5) continue;
            nrd++;
            if (bad(i)) begin stop = 1; continue; end
            p = int'(mem[i]);
            if (p == 16'hFFFF || p == 0 || p >= wsz) continue;
            nrd++;
            if (bad(p)) begin stop = 1; continue; end
            l = int'(mem[p]);
            if (l == 16'hFFFF || l == 0 || p + l >= wsz) continue;
            for (int j = p + 1; j <= p + l; j++) begin
                nrd++;
                if (bad(j)) break;
                s += mem[j];
            end
        end
        res = 16'hBABA - s;
        mm  = 1'b0;
        if (vfy) begin
            nrd++;
            mm = bad(63) || (mem[63] != res);
        end
    endfunction

    task automatic wipe(input logic [15:0] fill);
        for (int a = 0; a < 1024; a++) mem[a] = fill;
    endtask

    task automatic hdr_pattern(input logic [15:0] seed);
        for (int a = 0; a < 64; a++) mem[a] = seed + 16'(a * 16'h0103);
        for (int a = 3; a < 16; a++) mem[a] = 16'h0000;
    endtask

    // One pass; optional second start pulse at cycle restart_at.
    task automatic run(input logic vfy, input int wsz, input int restart_at,
                       output int nrd, output int ndone);
        int base;
        @(negedge clk);
        base   = rd_total;
        verify = vfy;
        words  = 17'(wsz);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        verify = ~vfy;
        ndone  = 0;
        for (int c = 1; c < 60000; c++) begin
            start = (c == restart_at);
            @(negedge clk);
            if (done) ndone++;
            else if (ndone > 0) break;
        end
        start = 1'b0;
        nrd   = rd_total - base;
    endtask

    task automatic exec(input string rq, input logic vfy, input int wsz, input int restart_at);
        logic [15:0] er;
        logic        em;
        int          en, nrd, nd;
        model(vfy, wsz, er, em, en);
        run(vfy, wsz, restart_at, nrd, nd);
        check({rq, " csum"}, 32'(csum), 32'(er));
        check({rq, " mismatch"}, 32'(mismatch), 32'(em));
        check({rq, " reads"}, 32'(nrd), 32'(en));
        check("R10 done width", 32'(nd), 32'd1);
        check("R10 idle after done", 32'(busy), 32'd0);
    endtask

    task automatic t_reset;
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 mismatch", 32'(mismatch), 0);
        check("R1 rd", 32'(mem_rd), 0);
    endtask

    task automatic t_header;
        wipe(16'h5A5A); hdr_pattern(16'h1234);
        exec("R2 header", 1'b0, 1024, 0);
        wipe(16'h0000);
        exec("R2 zero image", 1'b0, 1024, 0);
        check("R2 constant", 32'(csum), 32'hBABA);
    endtask

    task automatic t_slots;
        wipe(16'h0101); hdr_pattern(16'h0F0F);
        for (int s = 3; s < 16; s++) begin
            int p = 100 + s * 40;
            int l = (s % 5) + 1;
            mem[s] = 16'(p);
            mem[p] = 16'(l);
            for (int k = 1; k <= l; k++) mem[p + k] = 16'(s * 16'h0111 + k);
        end
        exec("R3 R6 slot walk", 1'b0, 1024, 0);
    endtask

    task automatic t_ranges;
        wipe(16'h0202); hdr_pattern(16'h2020);
        mem[3] = 16'hFFFF;
        mem[6] = 16'h0000;
        mem[7] = 16'd1024;
        mem[8] = 16'd1023; mem[1023] = 16'd1;
        mem[9] = 16'd200;  mem[200] = 16'd0;
        mem[10] = 16'd300; mem[300] = 16'hFFFF;
        mem[11] = 16'd400; mem[400] = 16'd623;
        mem[12] = 16'd600; mem[600] = 16'd4;
        exec("R4 R5 limits 1024", 1'b0, 1024, 0);
        exec("R4 R5 limits 512", 1'b0, 512, 0);
    endtask

    task automatic t_verify;
        logic [15:0] er;
        logic        em;
        int          en;
        wipe(16'h0303); hdr_pattern(16'h4444);
        mem[6] = 16'd500; mem[500] = 16'd3;
        model(1'b0, 1024, er, em, en);
        mem[63] = er;
        exec("R7 verify match", 1'b1, 1024, 0);
        mem[63] = er ^ 16'h0001;
        exec("R7 verify differ", 1'b1, 1024, 0);
        exec("R7 no verify", 1'b0, 1024, 0);
    endtask

    task automatic t_errors;
        wipe(16'h0404); hdr_pattern(16'h5151);
        mem[3] = 16'd200; mem[200] = 16'd5;
        mem[8] = 16'd300; mem[300] = 16'd4;
        mem[12] = 16'd400; mem[400] = 16'd2;
        err_en = 1'b1;
        err_addr = 10;  exec("R8 header error", 1'b0, 1024, 0);
        err_addr = 202; exec("R8 section error", 1'b0, 1024, 0);
        err_addr = 8;   exec("R8 pointer error", 1'b0, 1024, 0);
        err_addr = 300; exec("R8 length error", 1'b0, 1024, 0);
        err_addr = 63;  exec("R8 verify error", 1'b1, 1024, 0);
        err_en = 1'b0;
    endtask

    task automatic t_restart;
        logic [15:0] held;
        wipe(16'h0505); hdr_pattern(16'h6060);
        mem[7] = 16'd700; mem[700] = 16'd6;
        exec("R11 restart ignored", 1'b0, 1024, 20);
        held = csum;
        repeat (5) @(negedge clk);
        check("R10 result held", 32'(csum), 32'(held));
        check("R9 single outstanding", 32'(overlap), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_header();
        t_slots();
        t_ranges();
        t_verify();
        t_errors();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule